// File: doc/BRIEF.md
# Scan-Loaded Event Counter

This block is an up/down event counter whose clock events are edges on an external condition input. It sits behind a test-access-port data register: an 8-bit serial shift register lets a scan controller preload the counter and read it back. The surrounding test logic supplies the current controller state, one-hot instruction flags and single-cycle capture, shift and update strobes. The block returns the serial shift output and an active-low terminal-count flag.

The condition input is brought into the single free-running clock domain through a two-stage synchronizer and then edge-detected. Counting happens only while the count instruction is active and the controller rests in Run-Test/Idle. A preload made through an update is remembered separately, so one capture flavour returns the live count and the other returns the last value loaded.

Top module: `scan_event_counter`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears the shift register, so scan_out is 0 on the next cycle; the counter value and the stored preload value are not changed by reset.
- R2: The shift register shifts one place per clock while shift_dr is high and a counter instruction is active; scan_in enters bit 7 and scan_out always shows bit 0, so a value leaves least-significant bit first.
- R3: A capture_dr strobe under the counter-scan instruction (ins_cnt_scan) copies the live count into the shift register.
- R4: A capture_dr strobe under the counter-read instruction (ins_cnt_read) copies the last preload value into the shift register instead of the live count.
- R5: An update_dr strobe under either counter instruction loads the shift register value into the counter and records it as the new preload value.
- R6: Events are counted only while ins_count is high and tap_state equals 4'hC (Run-Test/Idle, with the standard 4-bit state code); counting continues from whatever the counter held before.
- R7: cfg_down = 0 counts up, cfg_down = 1 counts down, one step per accepted event; the count wraps modulo 256 unless R8 applies.
- R8: With cfg_down = 1 and cfg_latch_zero = 1 the counter stops at 8'h00 and ignores later events; cfg_latch_zero has no effect when counting up.
- R9: tc_n is 0 when the count is 8'h00 in down mode or 8'hFF in up mode, and 1 otherwise.
- R10: cfg_fall_edge = 0 counts low-to-high transitions of cond_in, 1 counts high-to-low transitions; a transition set up before rising edge k is counted at rising edge k+2 (synchronizer plus edge detector), and each transition counts once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_in | input | 1 | Asynchronous external condition input whose edges are counted |
| cfg_down | input | 1 | Count direction: 0 up, 1 down |
| cfg_latch_zero | input | 1 | Stop at zero when counting down |
| cfg_fall_edge | input | 1 | Edge select: 0 rising, 1 falling |
| tap_state | input | 4 | Current controller state, standard 4-bit code |
| ins_count | input | 1 | Count instruction active |
| ins_cnt_scan | input | 1 | Counter-scan instruction active |
| ins_cnt_read | input | 1 | Counter-read instruction active |
| capture_dr | input | 1 | Capture strobe, one cycle |
| shift_dr | input | 1 | Shift enable, one cycle per bit |
| update_dr | input | 1 | Update strobe, one cycle |
| scan_in | input | 1 | Serial data into the shift register |
| scan_out | output | 1 | Serial data out, bit 0 of the shift register |
| tc_n | output | 1 | Active-low terminal-count flag |

## Verification
A change on cond_in reaches the count three rising edges after it is driven (two synchronizer stages and the count register), so the bench drives it on a falling edge and waits at least four further falling edges before reading, and one latency check samples tc_n after exactly two and exactly three rising edges. A capture, each shift and an update each take effect on the rising edge where the strobe is high, so scan_out is sampled on the following falling edge, one bit per cycle, and tc_n, which is combinational from the count, is compared one falling edge after the last event or update. Counts are read through a counter-scan transfer that shifts the expected value back in, so a readback never alters the state the next scenario relies on.

// File: rtl/scnt_pkg.sv
package scnt_pkg;

    localparam int CNT_W       = 8;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [3:0] {
        ST_EXIT2_DR  = 4'h0,
        ST_EXIT1_DR  = 4'h1,
        ST_SHIFT_DR  = 4'h2,
        ST_PAUSE_DR  = 4'h3,
        ST_SEL_IR    = 4'h4,
        ST_UPDATE_DR = 4'h5,
        ST_CAPT_DR   = 4'h6,
        ST_SEL_DR    = 4'h7,
        ST_EXIT2_IR  = 4'h8,
        ST_EXIT1_IR  = 4'h9,
        ST_SHIFT_IR  = 4'hA,
        ST_PAUSE_IR  = 4'hB,
        ST_RUN_IDLE  = 4'hC,
        ST_UPDATE_IR = 4'hD,
        ST_CAPT_IR   = 4'hE,
        ST_RESET     = 4'hF
    } tap_state_e;

    typedef struct packed {
        logic down;
        logic latch_zero;
        logic fall_edge;
    } cnt_cfg_t;

    typedef enum logic [1:0] {
        CAP_NONE    = 2'd0,
        CAP_LIVE    = 2'd1,
        CAP_PRELOAD = 2'd2
    } cap_src_e;

    function automatic cap_src_e pick_capture(input logic scan_ins, input logic read_ins);
        if (read_ins)      return CAP_PRELOAD;
        else if (scan_ins) return CAP_LIVE;
        else               return CAP_NONE;
    endfunction

endpackage

// File: rtl/scnt_edge_det.sv
module scnt_edge_det
    import scnt_pkg::*;
#(
    parameter int STAGES = SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic fall_sel,
    output logic evt
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[TOP-1:0], din};
            prev_q <= sync_q[TOP];
        end
    end

    assign cur = sync_q[TOP];
    assign evt = fall_sel ? (prev_q & ~cur) : (cur & ~prev_q);

    AST_EVT_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        evt |=> !evt); // R10

endmodule

// File: rtl/scnt_core.sv
module scnt_core
    import scnt_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  cnt_cfg_t     cfg,
    input  logic         count_en,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic [W-1:0] preload,
    output logic         tc_n
);
    localparam logic [W-1:0] ALL_ZERO = '0;
    localparam logic [W-1:0] ALL_ONE  = '1;

    logic at_zero;
    logic at_full;
    logic held;

    assign at_zero = (count == ALL_ZERO);
    assign at_full = (count == ALL_ONE);
    assign held    = cfg.down & cfg.latch_zero & at_zero;

    // counter and preload value deliberately survive reset
    always_ff @(posedge clk) begin
        if (load) begin
            count   <= load_val;
            preload <= load_val;
        end else if (count_en && !held) begin
            if (cfg.down) count <= count - 1'b1;
            else          count <= count + 1'b1;
        end
    end

    always_comb begin
        if (cfg.down) tc_n = ~at_zero;
        else          tc_n = ~at_full;
    end

    AST_UPDATE_LOADS: assert property (@(posedge clk) disable iff (rst)
        load |=> (count == $past(load_val)) && (preload == $past(load_val))); // R5

    AST_COUNT_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!load && !count_en) |=> $stable(count)); // R6

    AST_LATCH_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!load && cfg.down && cfg.latch_zero && at_zero) |=> (count == ALL_ZERO)); // R8

    AST_UP_STEP: assert property (@(posedge clk) disable iff (rst)
        (!load && count_en && !cfg.down) |=> (count == $past(count) + 1'b1)); // R7

    AST_PRELOAD_STABLE: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(preload)); // R4

endmodule

// File: rtl/scnt_shift.sv
module scnt_shift
    import scnt_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         capture_en,
    input  logic [W-1:0] capture_val,
    input  logic         shift_en,
    input  logic         sin,
    output logic [W-1:0] sr,
    output logic         sout
);
    always_ff @(posedge clk) begin
        if (rst)             sr <= '0;
        else if (capture_en) sr <= capture_val;
        else if (shift_en)   sr <= {sin, sr[W-1:1]};
    end

    assign sout = sr[0];

    AST_SR_CLEARED: assert property (@(posedge clk)
        rst |=> (sr == '0)); // R1

    AST_SHIFT_TOWARD_OUT: assert property (@(posedge clk) disable iff (rst)
        (shift_en && !capture_en) |=> (sr[W-2:0] == $past(sr[W-1:1])) && (sr[W-1] == $past(sin))); // R2

endmodule

// File: rtl/scan_event_counter.sv
module scan_event_counter
    import scnt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cond_in,
    input  logic       cfg_down,
    input  logic       cfg_latch_zero,
    input  logic       cfg_fall_edge,
    input  logic [3:0] tap_state,
    input  logic       ins_count,
    input  logic       ins_cnt_scan,
    input  logic       ins_cnt_read,
    input  logic       capture_dr,
    input  logic       shift_dr,
    input  logic       update_dr,
    input  logic       scan_in,
    output logic       scan_out,
    output logic       tc_n
);
    cnt_cfg_t         cfg;
    cap_src_e         cap_src;
    logic             dr_sel;
    logic             in_idle;
    logic             evt;
    logic             count_en;
    logic             capture_en;
    logic             shift_en;
    logic             load;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] preload;
    logic [CNT_W-1:0] capture_val;
    logic [CNT_W-1:0] sr;

    assign cfg.down       = cfg_down;
    assign cfg.latch_zero = cfg_latch_zero;
    assign cfg.fall_edge  = cfg_fall_edge;

    assign dr_sel     = ins_cnt_scan | ins_cnt_read;
    assign in_idle    = (tap_state == ST_RUN_IDLE);
    assign count_en   = evt & ins_count & in_idle;
    assign cap_src    = pick_capture(ins_cnt_scan, ins_cnt_read);
    assign capture_en = capture_dr & (cap_src != CAP_NONE);
    assign shift_en   = shift_dr & dr_sel;
    assign load       = update_dr & dr_sel;

    always_comb begin
        case (cap_src)
            CAP_PRELOAD: capture_val = preload;
            CAP_LIVE:    capture_val = count;
            default:     capture_val = '0;
        endcase
    end

    scnt_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .din      (cond_in),
        .fall_sel (cfg.fall_edge),
        .evt      (evt)
    );

    scnt_core #(.W(CNT_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .cfg      (cfg),
        .count_en (count_en),
        .load     (load),
        .load_val (sr),
        .count    (count),
        .preload  (preload),
        .tc_n     (tc_n)
    );

    scnt_shift #(.W(CNT_W)) u_shift (
        .clk         (clk),
        .rst         (rst),
        .capture_en  (capture_en),
        .capture_val (capture_val),
        .shift_en    (shift_en),
        .sin         (scan_in),
        .sr          (sr),
        .sout        (scan_out)
    );

    AST_CAPTURE_LIVE: assert property (@(posedge clk) disable iff (rst)
        (capture_dr && ins_cnt_scan && !ins_cnt_read) |=> (sr == $past(count))); // R3

    AST_CAPTURE_PRELOAD: assert property (@(posedge clk) disable iff (rst)
        (capture_dr && ins_cnt_read) |=> (sr == $past(preload))); // R4

    AST_NO_COUNT_OUTSIDE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!in_idle && !load) |=> (count == $past(count))); // R6

endmodule

// File: tb/test_scan_event_counter.sv
module test_scan_event_counter;

    logic       clk = 1'b0;
    logic       rst;
    logic       cond_in;
    logic       cfg_down;
    logic       cfg_latch_zero;
    logic       cfg_fall_edge;
    logic [3:0] tap_state;
    logic       ins_count;
    logic       ins_cnt_scan;
    logic       ins_cnt_read;
    logic       capture_dr;
    logic       shift_dr;
    logic       update_dr;
    logic       scan_in;
    logic       scan_out;
    logic       tc_n;

    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    scan_event_counter i_scan_event_counter (
        .clk            (clk),
        .rst            (rst),
        .cond_in        (cond_in),
        .cfg_down       (cfg_down),
        .cfg_latch_zero (cfg_latch_zero),
        .cfg_fall_edge  (cfg_fall_edge),
        .tap_state      (tap_state),
        .ins_count      (ins_count),
        .ins_cnt_scan   (ins_cnt_scan),
        .ins_cnt_read   (ins_cnt_read),
        .capture_dr     (capture_dr),
        .shift_dr       (shift_dr),
        .update_dr      (update_dr),
        .scan_in        (scan_in),
        .scan_out       (scan_out),
        .tc_n           (tc_n)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // capture, shift eight bits, update; dout holds what left scan_out
    task automatic scan_xfer(input logic read_mode, input logic [7:0] din, output logic [7:0] dout);
        ins_count    = 1'b0;
        tap_state    = 4'h6;
        ins_cnt_scan = ~read_mode;
        ins_cnt_read = read_mode;
        capture_dr   = 1'b1;
        @(negedge clk);
        capture_dr = 1'b0;
        tap_state  = 4'h2;
        shift_dr   = 1'b1;
        for (int i = 0; i < 8; i++) begin
            scan_in = din[i];
            dout[i] = scan_out;
            @(negedge clk);
        end
        shift_dr  = 1'b0;
        tap_state = 4'h5;
        update_dr = 1'b1;
        @(negedge clk);
        update_dr    = 1'b0;
        ins_cnt_scan = 1'b0;
        ins_cnt_read = 1'b0;
        tap_state    = 4'hC;
    endtask

    task automatic load_val(input logic [7:0] v);
        logic [7:0] d;
        scan_xfer(1'b0, v, d);
    endtask

    // read live count, writing back the expected value
    task automatic read_check(input string req, input logic [7:0] exp);
        logic [7:0] d;
        scan_xfer(1'b0, exp, d);
        chk(req, d, exp);
    endtask

    task automatic run_mode(input logic on, input logic [3:0] st);
        ins_count = on;
        tap_state = st;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            cond_in = 1'b1; idle(5);
            cond_in = 1'b0; idle(5);
        end
    endtask

    task automatic t_reset_state;
        chk("R1 scan_out after reset", {7'b0, scan_out}, 8'h00);
    endtask

    task automatic t_load_readback;
        load_val(8'h5A);
        read_check("R5/R3/R2 load then readback 5A", 8'h5A);
        load_val(8'hC3);
        read_check("R5/R2 load then readback C3", 8'hC3);
    endtask

    task automatic t_count_up;
        cfg_down = 1'b0; cfg_latch_zero = 1'b0; cfg_fall_edge = 1'b0;
        load_val(8'h10);
        run_mode(1'b1, 4'hC);
        pulses(3);
        run_mode(1'b0, 4'hC);
        read_check("R6/R7 up count from 10 by 3", 8'h13);
    endtask

    task automatic t_gating;
        load_val(8'h30);
        run_mode(1'b1, 4'hD);
        pulses(2);
        run_mode(1'b0, 4'hC);
        pulses(2);
        read_check("R6 no count outside idle or without instruction", 8'h30);
    endtask

    task automatic t_preload_vs_live;
        logic [7:0] d;
        load_val(8'h20);
        run_mode(1'b1, 4'hC);
        pulses(5);
        run_mode(1'b0, 4'hC);
        scan_xfer(1'b1, 8'h25, d);
        chk("R4 counter-read capture returns preload", d, 8'h20);
        read_check("R3 counter-scan capture returns live count", 8'h25);
    endtask

    task automatic t_down_latch;
        cfg_down = 1'b1; cfg_latch_zero = 1'b1;
        load_val(8'h02);
        run_mode(1'b1, 4'hC);
        pulses(3);
        chk("R9 tc_n low at zero counting down", {7'b0, tc_n}, 8'h00);
        run_mode(1'b0, 4'hC);
        read_check("R8 latch at zero holds 00", 8'h00);
        cfg_latch_zero = 1'b0;
        run_mode(1'b1, 4'hC);
        pulses(1);
        run_mode(1'b0, 4'hC);
        chk("R9 tc_n high at FF counting down", {7'b0, tc_n}, 8'h01);
        read_check("R7 down wrap 00 to FF", 8'hFF);
    endtask

    task automatic t_up_wrap;
        cfg_down = 1'b0; cfg_latch_zero = 1'b1;
        load_val(8'hFE);
        chk("R9 tc_n high at FE counting up", {7'b0, tc_n}, 8'h01);
        run_mode(1'b1, 4'hC);
        pulses(1);
        chk("R9 tc_n low at FF counting up", {7'b0, tc_n}, 8'h00);
        pulses(1);
        run_mode(1'b0, 4'hC);
        read_check("R8/R7 latch ignored up, wrap FF to 00", 8'h00);
        cfg_latch_zero = 1'b0;
    endtask

    task automatic t_falling_edge;
        cfg_down = 1'b0; cfg_fall_edge = 1'b1;
        load_val(8'h40);
        run_mode(1'b1, 4'hC);
        cond_in = 1'b1; idle(5);
        run_mode(1'b0, 4'hC);
        read_check("R10 rising edge not counted in falling mode", 8'h40);
        run_mode(1'b1, 4'hC);
        cond_in = 1'b0; idle(5);
        run_mode(1'b0, 4'hC);
        read_check("R10 falling edge counted", 8'h41);
        cfg_fall_edge = 1'b0;
    endtask

    task automatic t_latency;
        cfg_down = 1'b0;
        load_val(8'hFE);
        run_mode(1'b1, 4'hC);
        cond_in = 1'b1;
        idle(2);
        chk("R10 not yet counted after two edges", {7'b0, tc_n}, 8'h01);
        idle(1);
        chk("R10 counted after three edges", {7'b0, tc_n}, 8'h00);
        cond_in = 1'b0; idle(5);
        run_mode(1'b0, 4'hC);
        read_check("R10 single count per edge", 8'hFF);
    endtask

    task automatic t_reset_keeps_count;
        load_val(8'h77);
        ins_cnt_scan = 1'b1; shift_dr = 1'b1; scan_in = 1'b1;
        idle(8);
        shift_dr = 1'b0; ins_cnt_scan = 1'b0;
        chk("R2 shifted ones reach scan_out", {7'b0, scan_out}, 8'h01);
        rst = 1'b1; idle(2); rst = 1'b0; idle(1);
        chk("R1 reset clears shift register", {7'b0, scan_out}, 8'h00);
        read_check("R1 counter survives reset", 8'h77);
    endtask

    initial begin
        rst = 1'b1; cond_in = 1'b0;
        cfg_down = 1'b0; cfg_latch_zero = 1'b0; cfg_fall_edge = 1'b0;
        tap_state = 4'hF; ins_count = 1'b0; ins_cnt_scan = 1'b0; ins_cnt_read = 1'b0;
        capture_dr = 1'b0; shift_dr = 1'b0; update_dr = 1'b0; scan_in = 1'b0;
        idle(3);
        rst = 1'b0;
        tap_state = 4'hC;
        idle(1);
        t_reset_state();
        t_load_readback();
        t_count_up();
        t_gating();
        t_preload_vs_live();
        t_down_latch();
        t_up_wrap();
        t_falling_edge();
        t_latency();
        t_reset_keeps_count();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule